// File: doc/BRIEF.md
# Rectangle Fill Command Engine

This block accepts 32-bit words that a host writes to one command port and turns each rectangle-fill packet into a raster stream of pixel writes. A packet is a command word followed by one pair of words for each rectangle. The first word of the pair gives the top-left corner and the second gives the size. The engine walks every rectangle row by row. It emits one pixel write per handshake on a valid/ready output, and each pixel carries the foreground colour that was held when its rectangle began.

Reading the command port returns a status word, not queued data. The status word carries a retrace flag taken from an input pin, a busy flag, a queue-empty flag, a sticky overflow flag and the number of free slots in the 16-word command queue. A host pushes packets while free space allows, then polls until busy clears. Once busy is low, every queued word has been consumed and every pixel has been emitted. A second register holds the foreground colour.

Top module: `rect_fill_engine`

## Requirements
- R1: A read at offset 0x00 returns status with bit 0 = retrace input, bit 2 = busy, bit 4 = queue empty, bit 8 = overflow and bits 31:16 = free queue slots. After reset, with retrace low, the value is 0x00100010.
- R2: A write at offset 0x00 to a non-full queue stores the word, and the free-slot field drops by one for each word not yet consumed.
- R3: A word with 0x86 in bits 31:24 starts a packet, and bits 15:0 give the rectangle count N. N pairs follow. In each pair, the first word holds x in bits 31:16 and y in bits 15:0, and the second word holds height in bits 31:16 and width in bits 15:0. A count of 0 consumes only the command word.
- R4: Pixels run from (x, y) to (x+w-1, y+h-1) with x advancing fastest, then y. Coordinates wrap modulo 2^16.
- R5: A rectangle with width 0 or height 0 emits no pixels.
- R6: A write at offset 0x44 loads the foreground colour, and a read there returns it. Every pixel carries the colour the register held when its rectangle started, even if the register is rewritten while the rectangle is being drawn.
- R7: A word at a packet-start position whose opcode is not 0x86 is dropped as a single word.
- R8: A write at offset 0x00 to a full queue (free = 0) is lost and sets overflow bit 8. The bit stays set until reset.
- R9: Busy is high while the queue holds words, a packet is partly consumed, or pixels remain to be sent. Busy is low once all of this is done.
- R10: While a pixel is valid but not accepted, valid, x, y and colour stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| retrace_in | input | 1 | Vertical retrace flag |
| px_valid | output | 1 | Pixel write valid |
| px_ready | input | 1 | Pixel sink ready |
| px_x | output | 16 | Pixel x |
| px_y | output | 16 | Pixel y |
| px_color | output | 32 | Pixel colour |

## Verification
Two functions can act in the same cycle: a host push into the queue and the parser's pop from it. A third case also shares a cycle: a write to the colour register lands while a rectangle is mid-walk. The bench provokes both by writing the colour and the second rectangle's words while the pixel sink is held stalled. The expected free-slot count is computed from the words written minus the words the packet rules say are consumed. Each pixel is compared against a queue built arithmetically from the corner, the size and the colour that was current at launch.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
   localparam logic [7:0] OP_RECT_FILL = 8'h86;

   localparam int ST_RETRACE  = 0;
   localparam int ST_BUSY     = 2;
   localparam int ST_EMPTY    = 4;
   localparam int ST_OVERFLOW = 8;
   localparam int ST_FREE_LSB = 16;

   typedef struct packed {
      logic [15:0] x;
      logic [15:0] y;
      logic [15:0] w;
      logic [15:0] h;
   } rect_t;

   typedef enum logic [1:0] {
      PS_CMD  = 2'd0,
      PS_POS  = 2'd1,
      PS_SIZE = 2'd2
   } pstate_e;
endpackage

// File: rtl/rfe_fifo.sv
module rfe_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH < 2) ? 1 : $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  rdata,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);
   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          push_ok, pop_ok;

   if (DEPTH < 2) begin : g_chk_depth
      $error("rfe_fifo: DEPTH must be at least 2");
   end

   if (DEPTH == (1 << AW)) begin : g_pow2
      assign wr_nxt = wr_ptr + AW'(1);
      assign rd_nxt = rd_ptr + AW'(1);
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
   end

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign rdata   = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_nxt;
         if (pop_ok)  rd_ptr <= rd_nxt;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end
endmodule

// File: rtl/rfe_parser.sv
module rfe_parser
   import rfe_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        word_valid,
   input  logic [31:0] word,
   input  logic        walker_idle,
   output logic        pop,
   output logic        launch,
   output rect_t       rect,
   output logic        idle
);
   pstate_e     state;
   logic [15:0] remain;
   logic [31:0] pos_q;

   assign idle = (state == PS_CMD);

   always_comb begin
      pop    = 1'b0;
      launch = 1'b0;
      case (state)
         PS_CMD, PS_POS: pop = word_valid;
         PS_SIZE: begin
            pop    = word_valid && walker_idle;
            launch = word_valid && walker_idle;
         end
         default: pop = 1'b0;
      endcase
      rect.x = pos_q[31:16];
      rect.y = pos_q[15:0];
      rect.h = word[31:16];
      rect.w = word[15:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= PS_CMD;
         remain <= '0;
         pos_q  <= '0;
      end else begin
         case (state)
            PS_CMD: if (word_valid && word[31:24] == OP_RECT_FILL && word[15:0] != 16'd0) begin
               remain <= word[15:0];
               state  <= PS_POS;
            end
            PS_POS: if (word_valid) begin
               pos_q <= word;
               state <= PS_SIZE;
            end
            PS_SIZE: if (launch) begin
               remain <= remain - 16'd1;
               state  <= (remain == 16'd1) ? PS_CMD : PS_POS;
            end
            default: state <= PS_CMD;
         endcase
      end
   end
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker
   import rfe_pkg::*;
#(
   parameter int CLR_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   input  rect_t            rect,
   input  logic [CLR_W-1:0] color_in,
   input  logic             px_ready,
   output logic             px_valid,
   output logic [15:0]      px_x,
   output logic [15:0]      px_y,
   output logic [CLR_W-1:0] px_color,
   output logic             idle
);
   logic             active;
   rect_t            base;
   logic [15:0]      col, row;
   logic [CLR_W-1:0] color_q;

   assign px_valid = active;
   assign idle     = !active;
   assign px_x     = base.x + col;
   assign px_y     = base.y + row;
   assign px_color = color_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active  <= 1'b0;
         base    <= '0;
         col     <= '0;
         row     <= '0;
         color_q <= '0;
      end else if (launch && !active) begin
         active  <= (rect.w != 16'd0) && (rect.h != 16'd0);
         base    <= rect;
         col     <= '0;
         row     <= '0;
         color_q <= color_in;
      end else if (active && px_ready) begin
         if (col == base.w - 16'd1) begin
            col <= '0;
            if (row == base.h - 16'd1) active <= 1'b0;
            else                       row    <= row + 16'd1;
         end else begin
            col <= col + 16'd1;
         end
      end
   end
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
   import rfe_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int CLR_W     = 32,
   parameter int ADDR_W    = 8,
   parameter int CMD_OFS   = 'h00,
   parameter int COLOR_OFS = 'h44,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   input  logic              retrace_in,
   output logic              px_valid,
   input  logic              px_ready,
   output logic [15:0]       px_x,
   output logic [15:0]       px_y,
   output logic [CLR_W-1:0]  px_color
);
   if (CLR_W < 1 || CLR_W > 32) begin : g_chk_clr
      $error("rect_fill_engine: CLR_W must be 1..32");
   end
   if (DEPTH > 65535) begin : g_chk_depth
      $error("rect_fill_engine: DEPTH must fit the 16-bit free field");
   end

   logic             cmd_sel, clr_sel, push, ovf_q, busy;
   logic             fifo_full, fifo_empty, pop, launch, parser_idle, walker_idle;
   logic [31:0]      head, status;
   logic [CW-1:0]    fifo_cnt;
   logic [CLR_W-1:0] fg_q;
   logic [15:0]      free_slots;
   rect_t            rect;

   assign cmd_sel = (bus_addr == ADDR_W'(CMD_OFS));
   assign clr_sel = (bus_addr == ADDR_W'(COLOR_OFS));
   assign push    = bus_wr && cmd_sel;

   rfe_fifo #(.W(32), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(bus_wdata),
      .pop(pop), .rdata(head), .count(fifo_cnt),
      .full(fifo_full), .empty(fifo_empty)
   );

   rfe_parser u_parser (
      .clk(clk), .rst_n(rst_n), .word_valid(!fifo_empty), .word(head),
      .walker_idle(walker_idle), .pop(pop), .launch(launch),
      .rect(rect), .idle(parser_idle)
   );

   rfe_walker #(.CLR_W(CLR_W)) u_walker (
      .clk(clk), .rst_n(rst_n), .launch(launch), .rect(rect),
      .color_in(fg_q), .px_ready(px_ready), .px_valid(px_valid),
      .px_x(px_x), .px_y(px_y), .px_color(px_color), .idle(walker_idle)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fg_q  <= '0;
         ovf_q <= 1'b0;
      end else begin
         if (bus_wr && clr_sel)  fg_q  <= bus_wdata[CLR_W-1:0];
         if (push && fifo_full)  ovf_q <= 1'b1;
      end
   end

   assign busy       = !fifo_empty || !parser_idle || !walker_idle;
   assign free_slots = 16'(DEPTH) - 16'(fifo_cnt);

   always_comb begin
      status                  = '0;
      status[ST_RETRACE]      = retrace_in;
      status[ST_BUSY]         = busy;
      status[ST_EMPTY]        = fifo_empty;
      status[ST_OVERFLOW]     = ovf_q;
      status[ST_FREE_LSB +: 16] = free_slots;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd && cmd_sel)      bus_rdata = status;
      else if (bus_rd && clr_sel) bus_rdata = 32'(fg_q);
   end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
   parameter int DEPTH = 16,
   parameter int CLR_W = 32,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             px_valid,
   input logic             px_ready,
   input logic [15:0]      px_x,
   input logic [15:0]      px_y,
   input logic [CLR_W-1:0] px_color,
   input logic             busy,
   input logic [CW-1:0]    fifo_cnt,
   input logic             ovf_q
);
   a_r10_hold_pixel: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid && !px_ready |=> px_valid && $stable(px_x) && $stable(px_y) && $stable(px_color));

   a_r9_busy_while_drawing: assert property (@(posedge clk) disable iff (!rst_n)
      px_valid |-> busy);

   a_r9_busy_while_queued: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt != '0 |-> busy);

   a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH));

   a_r8_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_q |=> ovf_q);
endmodule

bind rect_fill_engine rfe_checker #(.DEPTH(DEPTH), .CLR_W(CLR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .px_valid(px_valid), .px_ready(px_ready),
   .px_x(px_x), .px_y(px_y), .px_color(px_color), .busy(busy),
   .fifo_cnt(fifo_cnt), .ovf_q(ovf_q)
);

// File: tb/rect_fill_engine_bench.sv
module rect_fill_engine_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0, bus_rdata;
   logic        retrace_in = 1'b0;
   logic        px_valid, px_ready = 1'b0;
   logic [15:0] px_x, px_y;
   logic [31:0] px_color;

   int checks = 0, errors = 0, cyc = 0;
   bit stall = 1'b0, done = 1'b0;
   logic [63:0] expq [$];

   always #5 clk = ~clk;

   rect_fill_engine u_rect_fill_engine (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .retrace_in(retrace_in), .px_valid(px_valid), .px_ready(px_ready),
      .px_x(px_x), .px_y(px_y), .px_color(px_color)
   );

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_rd = 1'b1; bus_addr = a;
      #1 v = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic add_rect(input logic [15:0] x, input logic [15:0] y,
                           input int w, input int h, input logic [31:0] c);
      for (int r = 0; r < h; r++)
         for (int k = 0; k < w; k++)
            expq.push_back({16'(x + 16'(k)), 16'(y + 16'(r)), c});
   endtask

   task automatic wait_idle(input string req);
      logic [31:0] s;
      s = 32'h4;
      for (int i = 0; i < 3000 && s[2]; i++) begin
         @(posedge clk); #2;
         rd(8'h00, s);
      end
      check(s[2] == 1'b0, req, s, 0);
      check(expq.size() == 0, req, expq.size(), 0);
      @(posedge clk); #1;
   endtask

   // pixel sink and comparator (R4, R6, R10)
   initial forever begin
      @(posedge clk); #2;
      cyc++;
      px_ready = stall ? 1'b0 : (cyc % 3 != 1);
   end

   initial begin
      logic [63:0] hold_v;
      bit          holding;
      holding = 1'b0;
      forever begin
         @(negedge clk);
         if (holding) begin
            check(px_valid && {px_x, px_y, px_color} == hold_v, "R10", {px_x, px_y, px_color}, hold_v);
            holding = 1'b0;
         end
         if (px_valid && !px_ready) begin
            holding = 1'b1;
            hold_v = {px_x, px_y, px_color};
         end
         if (px_valid && px_ready) begin
            if (expq.size() == 0) check(1'b0, "R5 unexpected pixel", {px_x, px_y, px_color}, 0);
            else begin
               logic [63:0] e;
               e = expq.pop_front();
               check({px_x, px_y, px_color} == e, "R4/R6 pixel", {px_x, px_y, px_color}, e);
            end
         end
      end
   end

   initial begin
      for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] s;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(posedge clk); #1;

      // R1 reset value and retrace bit
      rd(8'h00, s);
      check(s == 32'h0010_0010, "R1 reset status", s, 32'h0010_0010);
      check(px_valid == 1'b0, "R1 no pixel after reset", px_valid, 0);
      retrace_in = 1'b1;
      rd(8'h00, s);
      check(s == 32'h0010_0011, "R1 retrace bit", s, 32'h0010_0011);
      retrace_in = 1'b0;

      // R6 colour register
      wr(8'h44, 32'hA1B2_C3D4);
      rd(8'h44, s);
      check(s == 32'hA1B2_C3D4, "R6 colour readback", s, 32'hA1B2_C3D4);

      // R3 R4 R5 sweep of sizes, corners near the 16-bit wrap
      for (int w = 0; w <= 4; w++)
         for (int h = 0; h <= 3; h++) begin
            logic [15:0] x0, y0;
            x0 = 16'hFFFD + 16'(w * 7);
            y0 = 16'hFFFE + 16'(h * 5);
            add_rect(x0, y0, w, h, 32'hA1B2_C3D4);
            wr(8'h00, 32'h8600_0001);
            wr(8'h00, {x0, y0});
            wr(8'h00, {16'(h), 16'(w)});
            wait_idle("R5/R9 sweep");
         end

      // R7 unknown opcode word, then R3 zero-count packet, then 3-rectangle packet
      wr(8'h44, 32'h0000_0055);
      wr(8'h00, 32'h1234_0002);
      wr(8'h00, 32'h8600_0000);
      wr(8'h00, 32'h8600_0003);
      add_rect(16'd10, 16'd20, 3, 2, 32'h55);
      wr(8'h00, {16'd10, 16'd20}); wr(8'h00, {16'd2, 16'd3});
      add_rect(16'd100, 16'd7, 1, 4, 32'h55);
      wr(8'h00, {16'd100, 16'd7}); wr(8'h00, {16'd4, 16'd1});
      add_rect(16'd5, 16'd5, 2, 2, 32'h55);
      wr(8'h00, {16'd5, 16'd5}); wr(8'h00, {16'd2, 16'd2});
      wait_idle("R7/R3 multi");

      // R2 R6 R8 R9: stalled sink, concurrent push/pop, colour change mid-walk
      stall = 1'b1;
      @(posedge clk); #3;
      wr(8'h44, 32'h0000_00C1);
      wr(8'h00, 32'h8600_0002);
      wr(8'h00, {16'd40, 16'd50});
      wr(8'h00, {16'd2, 16'd3});
      wr(8'h00, {16'd60, 16'd70});
      add_rect(16'd40, 16'd50, 3, 2, 32'hC1);
      add_rect(16'd60, 16'd70, 2, 2, 32'hC2);
      repeat (3) @(posedge clk);
      #1;
      rd(8'h00, s);
      check(s == 32'h0010_0014, "R9 busy with empty queue mid-packet", s, 32'h0010_0014);
      wr(8'h44, 32'h0000_00C2);
      wr(8'h00, {16'd2, 16'd2});
      rd(8'h00, s);
      check(s[31:16] == 16'd15, "R2 free after one word", s[31:16], 15);
      for (int i = 0; i < 15; i++) wr(8'h00, 32'h0100_0000 + i);
      rd(8'h00, s);
      check(s[31:16] == 16'd0 && s[8] == 1'b0, "R8 full, no overflow yet", s, 32'h0000_0004);
      wr(8'h00, 32'h8600_0001);
      rd(8'h00, s);
      check(s == 32'h0000_0104, "R8 overflow set, busy, full", s, 32'h0000_0104);
      stall = 1'b0;
      wait_idle("R9 drain after stall");
      rd(8'h00, s);
      check(s == 32'h0010_0110, "R8 overflow sticky, queue empty", s, 32'h0010_0110);
      rd(8'h44, s);
      check(s == 32'h0000_00C2, "R6 colour after change", s, 32'hC2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule